// File: doc/BRIEF.md
# Castout Victim Cache Slice with Lateral Spill

This block is a lower-level cache slice that sits under an upper-level cache and holds the lines that cache throws away. Every line the upper cache evicts arrives on the castout port, whether it was modified or not. Each line is 128 bytes, aligned on a 128-byte boundary, and carries a dirty flag. When the upper cache later misses, it presents the address on the lookup port. A hit returns the block and its dirty flag, and the line leaves this slice. The slice never keeps a copy of a line that it has handed back.

The slice is set-associative. The set index comes from the physical block address and the way is found by tag compare. Within a set an age order is kept, and the oldest line makes room when a new line arrives. An evicted line goes sideways into a peer slice if that peer signals that it has spare capacity. Otherwise a dirty line is written back to memory and a clean line is dropped. The slice raises its own accept flag for spill-in traffic when its local source has gone quiet for a while, or when a mode input switches the local source off. In that mode the slice only serves as a spill target for its peers.

Each cycle handles at most one operation, and all results appear as one-cycle registered pulses on the cycle after the operation.

Top module: `castout_victim_slice`

## Requirements
- R1: After reset, no line is valid, every output valid strobe is low, and `spill_accept` is low while `local_off` is low.
- R2: An accepted castout stores the line with its dirty flag, clean or dirty. A later lookup of any byte address inside the same 128-byte block answers one cycle later with `rsp_valid`=1, `rsp_hit`=1, the stored data and the stored dirty flag. A lookup of an absent block answers with `rsp_hit`=0.
- R3: A lookup hit removes the line from the slice, so a repeated lookup of the same block misses.
- R4: A castout or spill-in whose block is already present overwrites that entry's data. The new dirty flag is the OR of the old and new flags, the entry becomes youngest, and no second copy is created.
- R5: The set is byte-address bits [7 +: log2(SETS)]. The tag is all bits above the set field. Blocks that share a set but differ in tag are held in separate ways.
- R6: A new line fills the lowest-numbered invalid way of its set. If the set is full, it replaces the way least recently written. Lookups do not count as a write for this order.
- R7: An evicted line goes out on the spill-out port, with its dirty flag, when `peer_accept` is high. Otherwise a dirty line goes out on the write-back port and a clean line is dropped with no output. Exactly one route is taken per eviction.
- R8: A line evicted to make room for a spill-in is never spilled onward. It is written back if dirty and dropped if clean, whatever the state of `peer_accept`.
- R9: `spill_accept` is high when `local_off` is high. It is also high once IDLE_CYC clock edges have passed since the last accepted local castout. A spill-in presented while `spill_accept` is low is ignored.
- R10: While `local_off` is high, the castout and lookup ports are ignored: nothing is stored and no response is produced.
- R11: When several requests arrive in one cycle, a castout wins over a lookup and a lookup wins over a spill-in. A losing request is ignored without a response.
- R12: Write-back and spill-out addresses are block aligned: the low 7 bits are zero and the upper bits rebuild the evicted block from its tag and set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_off | input | 1 | Mode: local upper-level source disabled, slice acts only as spill target |
| co_valid | input | 1 | Castout from upper cache present |
| co_addr | input | PA_W | Castout byte address |
| co_data | input | LINE_BYTES*8 | Castout line data |
| co_dirty | input | 1 | Castout line modified |
| lk_valid | input | 1 | Upper-level miss lookup present |
| lk_addr | input | PA_W | Lookup byte address |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | LINE_BYTES*8 | Returned line data |
| rsp_dirty | output | 1 | Returned line is modified |
| wb_valid | output | 1 | Memory write-back strobe |
| wb_addr | output | PA_W | Write-back block address |
| wb_data | output | LINE_BYTES*8 | Write-back line data |
| peer_accept | input | 1 | Peer slice is lightly loaded and takes spills |
| so_valid | output | 1 | Spill-out strobe to peer |
| so_addr | output | PA_W | Spill-out block address |
| so_data | output | LINE_BYTES*8 | Spill-out line data |
| so_dirty | output | 1 | Spill-out line modified |
| si_valid | input | 1 | Spill-in from a peer present |
| si_addr | input | PA_W | Spill-in byte address |
| si_data | input | LINE_BYTES*8 | Spill-in line data |
| si_dirty | input | 1 | Spill-in line modified |
| spill_accept | output | 1 | This slice takes spill-in lines |

## Verification
The hardest situation to reach is an eviction that is forced by a spill-in while the peer is accepting. The spill-in is only taken once the slice has seen no local castout for IDLE_CYC cycles, and the target set must already be full of lines that the local port put there earlier. The stimulus first fills a set, then holds the local port idle until `spill_accept` rises, raises `peer_accept`, and only then drives the spill-in, so that R8 decides the route. A long deterministic pseudo-random sweep over a small pool of tags and sets then mixes every request type, the mode input and `peer_accept`. The sweep is compared against a recency model kept with write stamps rather than ranks.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SPILL = 2'd1,
    EV_WB    = 2'd2,
    EV_DROP  = 2'd3
  } ev_route_e;

  // New age rank of a way holding rank r when the way holding rank rt is touched.
  // young: touched way becomes rank 0, younger ones shift older by one.
  // old:   touched way becomes rank ways-1, older ones shift younger by one.
  function automatic int unsigned age_next(int unsigned r, int unsigned rt,
                                           logic young, int unsigned ways);
    if (young) begin
      if (r == rt) return 0;
      if (r < rt) return r + 1;
      return r;
    end
    if (r == rt) return ways - 1;
    if (r > rt) return r - 1;
    return r;
  endfunction

  // Where an eviction goes.
  function automatic ev_route_e route_evict(logic vic_valid, logic vic_dirty,
                                            logic peer_ok, logic from_spill);
    if (!vic_valid) return EV_NONE;
    if (peer_ok && !from_spill) return EV_SPILL;
    if (vic_dirty) return EV_WB;
    return EV_DROP;
  endfunction

endpackage

// File: rtl/vc_way_match.sv
module vc_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       valid_row,
  input  logic [WAYS*TAG_W-1:0] tag_row,
  input  logic [WAYS*WAY_W-1:0] rank_row,
  input  logic [TAG_W-1:0]      probe_tag,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      vic_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_row[w] && (tag_row[w*TAG_W +: TAG_W] == probe_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // Lowest invalid way first, else the oldest rank.
  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_row[w*WAY_W +: WAY_W] == OLDEST) vic_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) vic_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/vc_age_rank.sv
module vc_age_rank
  import vc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      set_i,
  output logic [WAYS*WAY_W-1:0] rank_row,
  input  logic                  tch_en,
  input  logic [WAY_W-1:0]      tch_way,
  input  logic                  tch_young
);

  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_rank;

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign rank_row[w*WAY_W +: WAY_W] = rank_q[set_i][w];
  end

  assign touched_rank = rank_q[set_i][tch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WAY_W'(w);
      end
    end else if (tch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        rank_q[set_i][w] <= WAY_W'(age_next(int'(rank_q[set_i][w]), int'(touched_rank),
                                            tch_young, WAYS));
      end
    end
  end

endmodule

// File: rtl/vc_idle_mon.sv
module vc_idle_mon #(
  parameter int IDLE_CYC = 8,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic local_off,
  input  logic local_cast,
  output logic spill_accept
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              quiet_q <= '0;
    else if (local_cast)     quiet_q <= '0;
    else if (quiet_q != LIMIT) quiet_q <= quiet_q + 1'b1;
  end

  assign spill_accept = local_off || (quiet_q == LIMIT);

endmodule

// File: rtl/castout_victim_slice.sv
module castout_victim_slice
  import vc_pkg::*;
#(
  parameter int PA_W       = 16,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int IDLE_CYC   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    local_off,
  input  logic                    co_valid,
  input  logic [PA_W-1:0]         co_addr,
  input  logic [LINE_BYTES*8-1:0] co_data,
  input  logic                    co_dirty,
  input  logic                    lk_valid,
  input  logic [PA_W-1:0]         lk_addr,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [LINE_BYTES*8-1:0] rsp_data,
  output logic                    rsp_dirty,
  output logic                    wb_valid,
  output logic [PA_W-1:0]         wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_data,
  input  logic                    peer_accept,
  output logic                    so_valid,
  output logic [PA_W-1:0]         so_addr,
  output logic [LINE_BYTES*8-1:0] so_data,
  output logic                    so_dirty,
  input  logic                    si_valid,
  input  logic [PA_W-1:0]         si_addr,
  input  logic [LINE_BYTES*8-1:0] si_data,
  input  logic                    si_dirty,
  output logic                    spill_accept
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = PA_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int CNT_W  = $clog2(IDLE_CYC + 1);

  function automatic logic [IDX_W-1:0] set_of(logic [PA_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [PA_W-1:0] a);
    return a[PA_W-1 -: TAG_W];
  endfunction

  function automatic logic [PA_W-1:0] block_addr(logic [TAG_W-1:0] t, logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // Storage
  logic              valid_q [SETS][WAYS];
  logic              dirty_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] data_q  [SETS][WAYS];

  // Request selection (named events for the checker)
  logic co_go, lk_go, si_go, ins_go;
  logic [PA_W-1:0]   op_addr;
  logic [LINE_W-1:0] in_data;
  logic              in_dirty;
  logic [IDX_W-1:0]  op_set;
  logic [TAG_W-1:0]  op_tag;

  assign co_go  = co_valid && !local_off;
  assign lk_go  = lk_valid && !local_off && !co_go;
  assign si_go  = si_valid && spill_accept && !co_go && !lk_go;
  assign ins_go = co_go || si_go;

  assign op_addr  = co_go ? co_addr : (lk_go ? lk_addr : si_addr);
  assign in_data  = co_go ? co_data : si_data;
  assign in_dirty = co_go ? co_dirty : si_dirty;
  assign op_set   = set_of(op_addr);
  assign op_tag   = tag_of(op_addr);

  // Row of the selected set
  logic [WAYS-1:0]       valid_row;
  logic [WAYS*TAG_W-1:0] tag_row;
  logic [WAYS*WAY_W-1:0] rank_row;

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign valid_row[w]                 = valid_q[op_set][w];
    assign tag_row[w*TAG_W +: TAG_W]    = tag_q[op_set][w];
  end

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way, wr_way;

  vc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_row (valid_row),
    .tag_row   (tag_row),
    .rank_row  (rank_row),
    .probe_tag (op_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way),
    .vic_way   (vic_way)
  );

  logic tch_en;
  assign wr_way = hit ? hit_way : vic_way;
  assign tch_en = ins_go || (lk_go && hit);

  vc_age_rank #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (op_set),
    .rank_row  (rank_row),
    .tch_en    (tch_en),
    .tch_way   (lk_go ? hit_way : wr_way),
    .tch_young (ins_go)
  );

  vc_idle_mon #(.IDLE_CYC(IDLE_CYC), .CNT_W(CNT_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .local_off    (local_off),
    .local_cast   (co_go),
    .spill_accept (spill_accept)
  );

  // Eviction decision
  logic      vic_live;
  ev_route_e ev_route;
  assign vic_live = ins_go && !hit && valid_q[op_set][vic_way];
  assign ev_route = route_evict(vic_live, dirty_q[op_set][vic_way], peer_accept, si_go);

  // Control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
        end
      end
    end else if (ins_go) begin
      valid_q[op_set][wr_way] <= 1'b1;
      tag_q[op_set][wr_way]   <= op_tag;
      dirty_q[op_set][wr_way] <= hit ? (dirty_q[op_set][wr_way] | in_dirty) : in_dirty;
    end else if (lk_go && hit) begin
      valid_q[op_set][hit_way] <= 1'b0;
      dirty_q[op_set][hit_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_go) data_q[op_set][wr_way] <= in_data;
  end

  // Registered result strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_data  <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      so_valid  <= 1'b0;
      so_addr   <= '0;
      so_data   <= '0;
      so_dirty  <= 1'b0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go && hit;
      rsp_dirty <= lk_go && hit && dirty_q[op_set][hit_way];
      rsp_data  <= data_q[op_set][hit_way];
      wb_valid  <= (ev_route == EV_WB);
      so_valid  <= (ev_route == EV_SPILL);
      wb_addr   <= block_addr(tag_q[op_set][vic_way], op_set);
      so_addr   <= block_addr(tag_q[op_set][vic_way], op_set);
      wb_data   <= data_q[op_set][vic_way];
      so_data   <= data_q[op_set][vic_way];
      so_dirty  <= dirty_q[op_set][vic_way];
    end
  end

endmodule

// File: rtl/vc_checks.sv
module vc_checks #(
  parameter int WAYS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            local_off,
  input logic            co_valid,
  input logic            lk_valid,
  input logic            peer_accept,
  input logic            spill_accept,
  input logic            rsp_valid,
  input logic            wb_valid,
  input logic            so_valid,
  input logic [WAYS-1:0] hit_vec,
  input logic            ins_go,
  input logic            si_go
);

  // R7: one route per eviction
  a_r7_single_route: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && so_valid));

  // R7: spill only toward an accepting peer
  a_r7_spill_needs_peer: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |-> $past(peer_accept));

  // R8: spill-in evictions never travel sideways again
  a_r8_no_respill: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |-> !$past(si_go));

  // R7: eviction strobes only follow an insertion
  a_r7_evict_after_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || so_valid) |-> $past(ins_go));

  // R10: no response to a lookup while the local source is off
  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(lk_valid) && !$past(local_off)));

  // R9: an accepted local castout closes the spill-in window
  a_r9_busy_after_cast: assert property (@(posedge clk) disable iff (!rst_n)
    (co_valid && !local_off) |=> (spill_accept == local_off));

  // R4: a block never sits in two ways
  a_r4_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

bind castout_victim_slice vc_checks #(.WAYS(WAYS)) u_vc_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .local_off    (local_off),
  .co_valid     (co_valid),
  .lk_valid     (lk_valid),
  .peer_accept  (peer_accept),
  .spill_accept (spill_accept),
  .rsp_valid    (rsp_valid),
  .wb_valid     (wb_valid),
  .so_valid     (so_valid),
  .hit_vec      (hit_vec),
  .ins_go       (ins_go),
  .si_go        (si_go)
);

// File: tb/castout_victim_slice_bench.sv
module castout_victim_slice_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PA_W   = 16;
  localparam int LB     = 128;
  localparam int LINE_W = LB * 8;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;
  localparam int IDLE   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              off = 0, co_v = 0, co_dy = 0, lk_v = 0, si_v = 0, si_dy = 0, peer = 0;
  logic [PA_W-1:0]   co_a = 0, lk_a = 0, si_a = 0;
  logic [LINE_W-1:0] co_d = 0, si_d = 0;

  logic              rsp_valid, rsp_hit, rsp_dirty, wb_valid, so_valid, so_dirty, spill_accept;
  logic [LINE_W-1:0] rsp_data, wb_data, so_data;
  logic [PA_W-1:0]   wb_addr, so_addr;

  castout_victim_slice #(.PA_W(PA_W), .LINE_BYTES(LB), .SETS(SETS), .WAYS(WAYS),
                         .IDLE_CYC(IDLE)) u_castout_victim_slice (
    .clk(clk), .rst_n(rst_n), .local_off(off),
    .co_valid(co_v), .co_addr(co_a), .co_data(co_d), .co_dirty(co_dy),
    .lk_valid(lk_v), .lk_addr(lk_a),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .peer_accept(peer),
    .so_valid(so_valid), .so_addr(so_addr), .so_data(so_data), .so_dirty(so_dirty),
    .si_valid(si_v), .si_addr(si_a), .si_data(si_d), .si_dirty(si_dy),
    .spill_accept(spill_accept)
  );

  int nchecks = 0;
  int nfail = 0;

  // Reference state: recency kept as write stamps
  bit          m_v [SETS][WAYS];
  bit          m_d [SETS][WAYS];
  int          m_t [SETS][WAYS];
  int          m_st[SETS][WAYS];
  logic [LINE_W-1:0] m_data[SETS][WAYS];
  int now = 1;
  int idle = 0;

  function automatic logic [LINE_W-1:0] pat(int a, int salt);
    return {32{32'(a * 40503 + salt * 977 + 17)}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [LINE_W-1:0] act,
                     logic [LINE_W-1:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock of stimulus with full comparison against the reference.
  task automatic cycle(string req);
    bit cg, lg, sg, acc, hit;
    int a, s, t, hw, vw, ea;
    bit e_rv = 0, e_rh = 0, e_ry = 0, e_wv = 0, e_sv = 0, e_sy = 0;
    logic [LINE_W-1:0] e_rd = '0, e_wd = '0, e_sd = '0, nd;
    int e_wa = 0, e_sa = 0;
    bit ndy;
    cg  = co_v && !off;
    lg  = lk_v && !off && !cg;
    acc = off || (idle >= IDLE);
    sg  = si_v && acc && !cg && !lg;
    a   = cg ? int'(co_a) : (lg ? int'(lk_a) : int'(si_a));
    s   = (a / LB) % SETS;
    t   = (a / LB) / SETS;
    hw  = -1;
    for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_t[s][w] == t) hw = w;
    hit = (hw >= 0);
    if (lg) begin
      e_rv = 1;
      if (hit) begin
        e_rh = 1; e_rd = m_data[s][hw]; e_ry = m_d[s][hw];
        m_v[s][hw] = 0; m_d[s][hw] = 0;
      end
    end
    if (cg || sg) begin
      nd  = cg ? co_d : si_d;
      ndy = cg ? co_dy : si_dy;
      if (hit) begin
        m_data[s][hw] = nd; m_d[s][hw] = m_d[s][hw] | ndy; m_st[s][hw] = now;
      end else begin
        vw = -1;
        for (int w = 0; w < WAYS; w++) if (!m_v[s][w] && vw < 0) vw = w;
        if (vw < 0) begin
          vw = 0;
          for (int w = 1; w < WAYS; w++) if (m_st[s][w] < m_st[s][vw]) vw = w;
          ea = (m_t[s][vw] * SETS + s) * LB;
          if (peer && cg) begin
            e_sv = 1; e_sa = ea; e_sd = m_data[s][vw]; e_sy = m_d[s][vw];
          end else if (m_d[s][vw]) begin
            e_wv = 1; e_wa = ea; e_wd = m_data[s][vw];
          end
        end
        m_v[s][vw] = 1; m_d[s][vw] = ndy; m_t[s][vw] = t;
        m_data[s][vw] = nd; m_st[s][vw] = now;
      end
    end
    if (cg) idle = 0;
    else if (idle < IDLE) idle++;
    now++;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === e_rv, req, "rsp_valid", LINE_W'(rsp_valid), LINE_W'(e_rv));
    if (e_rv) begin
      chk(rsp_hit === e_rh, req, "rsp_hit", LINE_W'(rsp_hit), LINE_W'(e_rh));
      if (e_rh) begin
        chk(rsp_data === e_rd, req, "rsp_data", rsp_data, e_rd);
        chk(rsp_dirty === e_ry, req, "rsp_dirty", LINE_W'(rsp_dirty), LINE_W'(e_ry));
      end
    end
    chk(wb_valid === e_wv, req, "wb_valid", LINE_W'(wb_valid), LINE_W'(e_wv));
    if (e_wv) begin
      chk(wb_addr === PA_W'(e_wa), req, "wb_addr (R12)", LINE_W'(wb_addr), LINE_W'(e_wa));
      chk(wb_data === e_wd, req, "wb_data", wb_data, e_wd);
    end
    chk(so_valid === e_sv, req, "so_valid", LINE_W'(so_valid), LINE_W'(e_sv));
    if (e_sv) begin
      chk(so_addr === PA_W'(e_sa), req, "so_addr (R12)", LINE_W'(so_addr), LINE_W'(e_sa));
      chk(so_data === e_sd, req, "so_data", so_data, e_sd);
      chk(so_dirty === e_sy, req, "so_dirty", LINE_W'(so_dirty), LINE_W'(e_sy));
    end
    acc = off || (idle >= IDLE);
    chk(spill_accept === acc, req, "spill_accept (R9)", LINE_W'(spill_accept), LINE_W'(acc));
    co_v = 0; lk_v = 0; si_v = 0;
  endtask

  function automatic int baddr(int tag, int set, int off_b);
    return (tag * SETS + set) * LB + off_b;
  endfunction

  task automatic cast(int a, bit dy, int salt, string req);
    co_v = 1; co_a = PA_W'(a); co_dy = dy; co_d = pat(a, salt);
    cycle(req);
  endtask

  task automatic look(int a, string req);
    lk_v = 1; lk_a = PA_W'(a);
    cycle(req);
  endtask

  task automatic spill_in(int a, bit dy, int salt, string req);
    si_v = 1; si_a = PA_W'(a); si_dy = dy; si_d = pat(a, salt);
    cycle(req);
  endtask

  task automatic spin(int n, string req);
    for (int i = 0; i < n; i++) cycle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin : main
    int seed;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; m_st[s][w] = 0; m_data[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: idle state out of reset
    chk(!rsp_valid && !wb_valid && !so_valid, "R1", "strobes", LINE_W'({rsp_valid, wb_valid, so_valid}), '0);
    chk(spill_accept === 1'b0, "R1", "spill_accept", LINE_W'(spill_accept), '0);
    look(baddr(1, 0, 0), "R1");

    // R2: clean and dirty castouts, lookup at an inner byte offset
    cast(baddr(3, 1, 0), 0, 1, "R2");
    cast(baddr(5, 2, 0), 1, 2, "R2");
    look(baddr(3, 1, 77), "R2");
    look(baddr(5, 2, 127), "R2");
    // R3: a hit removes the line
    look(baddr(3, 1, 0), "R3");
    look(baddr(5, 2, 4), "R3");

    // R4: overwrite with dirty merge, no duplicate
    cast(baddr(6, 3, 0), 1, 3, "R4");
    cast(baddr(6, 3, 9), 0, 4, "R4");
    cast(baddr(7, 3, 0), 0, 5, "R4");
    look(baddr(6, 3, 0), "R4");
    look(baddr(7, 3, 0), "R4");

    // R5/R6/R7: fill set 0, evict oldest to memory, to peer, and drop
    peer = 0;
    cast(baddr(1, 0, 0), 1, 6, "R5");
    cast(baddr(2, 0, 0), 0, 7, "R5");
    cast(baddr(3, 0, 0), 0, 8, "R6");   // evicts tag 1 dirty -> write-back
    cast(baddr(4, 0, 0), 0, 9, "R7");   // evicts tag 2 clean -> dropped
    cast(baddr(3, 0, 0), 1, 10, "R6");  // refresh tag 3
    peer = 1;
    cast(baddr(5, 0, 0), 0, 11, "R7");  // evicts tag 4 -> spill-out
    cast(baddr(6, 0, 0), 0, 12, "R7");  // evicts tag 3 dirty -> spill-out
    look(baddr(5, 0, 0), "R6");         // lookup does not change order
    peer = 0;

    // R9: window closed after castout, opens after IDLE edges
    si_v = 1; si_a = PA_W'(baddr(2, 1, 0)); si_d = pat(1, 1); si_dy = 1;
    cycle("R9");
    look(baddr(2, 1, 0), "R9");
    spin(IDLE, "R9");
    // R8: spill-in into a full set with peer accepting
    cast(baddr(8, 2, 0), 1, 13, "R8");
    cast(baddr(9, 2, 0), 0, 14, "R8");
    spin(IDLE, "R8");
    peer = 1;
    spill_in(baddr(10, 2, 0), 0, 15, "R8");  // evicts dirty tag 8 -> write-back only
    spill_in(baddr(11, 2, 0), 1, 16, "R8");  // evicts clean tag 9 -> dropped
    spill_in(baddr(10, 2, 0), 1, 17, "R4");  // merge on spill-in
    peer = 0;

    // R10: local source off
    off = 1;
    cycle("R10");
    cast(baddr(12, 1, 0), 1, 18, "R10");
    look(baddr(10, 2, 0), "R10");
    spill_in(baddr(13, 1, 0), 1, 19, "R10");
    off = 0;
    look(baddr(12, 1, 0), "R10");
    look(baddr(13, 1, 0), "R10");

    // R11: simultaneous requests
    co_v = 1; co_a = PA_W'(baddr(14, 3, 0)); co_d = pat(5, 5); co_dy = 0;
    lk_v = 1; lk_a = PA_W'(baddr(14, 3, 0));
    si_v = 1; si_a = PA_W'(baddr(15, 3, 0)); si_d = pat(6, 6); si_dy = 1;
    cycle("R11");
    lk_v = 1; lk_a = PA_W'(baddr(14, 3, 0));
    si_v = 1; si_a = PA_W'(baddr(15, 3, 0));
    cycle("R11");
    look(baddr(15, 3, 0), "R11");

    // Sweep over a small tag pool with mixed requests and modes
    seed = 12345;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      co_v  = seed[16];
      lk_v  = seed[17] & seed[18];
      si_v  = seed[19];
      co_dy = seed[20];
      si_dy = seed[21];
      peer  = seed[22];
      off   = (seed[25:23] == 3'd0);
      co_a  = PA_W'(baddr(int'(seed[27:26]), int'(seed[29:28]), int'(seed[6:0])));
      lk_a  = PA_W'(baddr(int'(seed[11:10]), int'(seed[13:12]), int'(seed[9:3])));
      si_a  = PA_W'(baddr(int'(seed[31:30]) + 2, int'(seed[15:14]), 0));
      co_d  = pat(i, 1);
      si_d  = pat(i, 2);
      if (seed[10:7] == 4'd0) spin(IDLE, "R9");
      cycle("R6");
    end
    off = 0; peer = 0;
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++) look(baddr(t, s, 0), "R2");

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule